// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a processor core out of reset. It watches an external active-low reset line and accepts a reset only after the line has stayed low for a minimum number of system clocks. Shorter glitches are discarded. Once an accepted reset is released, the block reads a 24-bit start address as three bytes over a byte-wide read port. It then loads the program counter and pulses a completion flag. After that pulse it lets the core run.

While reset is in force, the block drives the architectural start-up values: a cleared stack pointer, a fully set interrupt mask and register bank zero. It also forces the clock unit into its slowest safe setting: PLL bypassed and divide-by-16 gear. It produces only these control values. The PLL, the clock divider and instruction fetch sit in other blocks.

Top module: `rst_vector_seq`

## Requirements
- R1: A low level on `ext_rst_n` is accepted as reset only when it is sampled low on MIN_LOW (default 20) consecutive rising clock edges. A shorter low pulse changes nothing: a running core keeps `core_run` high and keeps its `pc`, and a held core stays held.
- R2: After an accepted reset is released, `rd_req` rises in the clock cycle after the first edge that samples `ext_rst_n` high. The three vector reads then use `rd_addr` FFFF00h, FFFF01h and FFFF02h, strictly in ascending order.
- R3: The byte read from FFFF00h becomes `pc[7:0]`, the byte from FFFF01h becomes `pc[15:8]` and the byte from FFFF02h becomes `pc[23:16]`.
- R4: Whenever it is observed, `sp` is 00000000h, `irq_mask` is 3'b111 and `bank_sel` is 2'b00. Each is set at reset acceptance and on `rst`.
- R5: While `core_run` is low, `pll_bypass_force` is 1 and `gear_sel` is 3'b100. The gear code is 0..4 for divide by 1, 2, 4, 8 and 16. While `core_run` is high, `pll_bypass_force` is 0 and `gear_sel` is 3'b111, which lets the clock unit keep its own setting.
- R6: `boot_done` is high for exactly one cycle: the cycle after the edge that completes the third read. `pc` already holds the vector in that cycle. `core_run` rises on the next cycle and never rises without a preceding `boot_done`.
- R7: A low on `ext_rst_n` during a vector read or during the `boot_done` cycle aborts the sequence. `rd_req` drops on the next cycle. Nothing runs until a new low of MIN_LOW consecutive clocks is accepted, and that low pulse itself counts as its first cycle.
- R8: From reset acceptance until the vector is loaded, `pc` reads 000000h.
- R9: While `rst` is high, the block enters its held state: `rd_req`, `boot_done` and `core_run` are 0 and `pc` is 0.
- R10: A read completes only on an edge where `rd_req` and `rd_rdy` are both high. While `rd_rdy` stays low, `rd_req` stays high and `rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_n | input | 1 | External reset request, active low, synchronous to clk |
| rd_req | output | 1 | Read strobe, high for the whole of each vector access |
| rd_addr | output | 24 | Byte address of the current vector access |
| rd_data | input | 8 | Read data byte |
| rd_rdy | input | 1 | Read completion, sampled while rd_req is high |
| pc | output | 24 | Program counter start value |
| sp | output | 32 | Stack pointer start value |
| irq_mask | output | 3 | Interrupt mask level start value |
| bank_sel | output | 2 | Register bank select start value |
| pll_bypass_force | output | 1 | Forces the PLL to be bypassed while the core is held |
| gear_sel | output | 3 | Clock gear code forced while held (7 = keep) |
| boot_done | output | 1 | One-cycle pulse once pc is loaded |
| core_run | output | 1 | High when the core may fetch instructions |

## Verification
If the low-time counter is off by one, `rd_req` shows it at once: a pulse of exactly MIN_LOW clocks either fails to start a read, or a pulse one clock shorter starts one. A wrong byte index shows up in the address of the very next access. A wrong byte lane shows up only at the `boot_done` cycle, as a `pc` with its bytes swapped. A state machine stuck outside its run state leaves the clock-force outputs set after the pulse. The scoreboard therefore compares every completed address, and the `pc` value at every completion pulse, against values it derives from its own memory model.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int SP_W   = 32;
    localparam int MASK_W = 3;
    localparam int BANK_W = 2;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_ARMED = 3'd1,
        ST_FETCH = 3'd2,
        ST_DONE  = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        GEAR_DIV1  = 3'd0,
        GEAR_DIV2  = 3'd1,
        GEAR_DIV4  = 3'd2,
        GEAR_DIV8  = 3'd3,
        GEAR_DIV16 = 3'd4,
        GEAR_KEEP  = 3'd7
    } gear_e;

    typedef struct packed {
        logic [SP_W-1:0]   sp;
        logic [MASK_W-1:0] mask;
        logic [BANK_W-1:0] bank;
    } arch_init_t;

    typedef struct packed {
        logic  bypass;
        gear_e gear;
    } clk_ctl_t;

    function automatic arch_init_t arch_reset_val();
        arch_init_t v;
        v.sp   = '0;
        v.mask = '1;
        v.bank = '0;
        return v;
    endfunction

    function automatic clk_ctl_t clk_ctl_for(seq_state_e st);
        clk_ctl_t c;
        if (st == ST_RUN) begin
            c.bypass = 1'b0;
            c.gear   = GEAR_KEEP;
        end else begin
            c.bypass = 1'b1;
            c.gear   = GEAR_DIV16;
        end
        return c;
    endfunction

endpackage

// File: rtl/rvs_lowqual.sv
module rvs_lowqual #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_low,
    output logic accept
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(MIN_LOW - 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !rst_low) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_SAT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign accept = rst_low && (low_cnt_q == CNT_HIT);

    // R1
    accept_once_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    // R1
    high_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_low |=> !accept);

endmodule

// File: rtl/rvs_vecasm.sv
module rvs_vecasm
    import rvs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    output logic              last,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] vec_next
);
    localparam int NBYTES = ADDR_W / DATA_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
        end else if (take && !last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign last = (idx_q == IDX_LAST);
    assign addr = VEC_BASE + ADDR_W'(idx_q);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        logic              hit;

        assign hit = take && (idx_q == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                lane_q <= '0;
            end else if (hit) begin
                lane_q <= data;
            end
        end

        assign vec_next[g*DATA_W +: DATA_W] = hit ? data : lane_q;
    end

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !last && !clr) |=> (idx_q == $past(idx_q) + 1'b1));

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> $stable(idx_q));

endmodule

// File: rtl/rvs_fsm.sv
module rvs_fsm
    import rvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_low,
    input  logic       accept,
    input  logic       take,
    input  logic       last,
    output seq_state_e state
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (accept) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!rst_low) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (rst_low)          state_d = ST_WAIT;
                else if (take && last) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = rst_low ? ST_WAIT : ST_RUN;
            end
            ST_RUN: begin
                if (accept) state_d = ST_ARMED;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q != ST_DONE));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_DONE));

    // R7
    fetch_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && rst_low) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/rst_vector_seq.sv
module rst_vector_seq
    import rvs_pkg::*;
#(
    parameter int                MIN_LOW  = 20,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_rdy,
    output logic [ADDR_W-1:0] pc,
    output logic [SP_W-1:0]   sp,
    output logic [MASK_W-1:0] irq_mask,
    output logic [BANK_W-1:0] bank_sel,
    output logic              pll_bypass_force,
    output logic [2:0]        gear_sel,
    output logic              boot_done,
    output logic              core_run
);
    logic        rst_low;
    logic        accept;
    logic        take;
    logic        last;
    logic [ADDR_W-1:0] vec_next;
    seq_state_e  state;
    arch_init_t  arch_q;
    clk_ctl_t    clk_ctl;
    logic [ADDR_W-1:0] pc_q;

    assign rst_low = !ext_rst_n;
    assign take    = (state == ST_FETCH) && rd_rdy && !rst_low;

    rvs_lowqual #(
        .MIN_LOW (MIN_LOW)
    ) i_lowqual (
        .clk     (clk),
        .rst     (rst),
        .rst_low (rst_low),
        .accept  (accept)
    );

    rvs_vecasm #(
        .VEC_BASE (VEC_BASE)
    ) i_vecasm (
        .clk      (clk),
        .rst      (rst),
        .clr      (state == ST_ARMED),
        .take     (take),
        .data     (rd_data),
        .last     (last),
        .addr     (rd_addr),
        .vec_next (vec_next)
    );

    rvs_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .rst_low (rst_low),
        .accept  (accept),
        .take    (take),
        .last    (last),
        .state   (state)
    );

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            pc_q <= '0;
        end else if (take && last) begin
            pc_q <= vec_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            arch_q <= arch_reset_val();
        end
    end

    assign clk_ctl          = clk_ctl_for(state);
    assign rd_req           = (state == ST_FETCH);
    assign boot_done        = (state == ST_DONE);
    assign core_run         = (state == ST_RUN);
    assign pc               = pc_q;
    assign sp               = arch_q.sp;
    assign irq_mask         = arch_q.mask;
    assign bank_sel         = arch_q.bank;
    assign pll_bypass_force = clk_ctl.bypass;
    assign gear_sel         = clk_ctl.gear;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_rdy && ext_rst_n) |=> (rd_req && $stable(rd_addr)));

    // R2
    addr_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req) && $past(rd_rdy)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R6
    done_then_run_chk: assert property (@(posedge clk) disable iff (rst)
        (boot_done && ext_rst_n) |=> (core_run && !boot_done));

    // R6
    run_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run) |-> $past(boot_done));

    // R7
    abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ext_rst_n) |=> (!rd_req && !core_run));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(core_run && rd_req));

    // R8
    pc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(!rd_req && !core_run && !boot_done)) |-> (pc == '0));

endmodule

// File: tb/test_rst_vector_seq.sv
`timescale 1ns/1ps
module test_rst_vector_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        rd_req;
    logic [23:0] rd_addr;
    logic [7:0]  rd_data;
    logic        rd_rdy = 1'b0;
    logic [23:0] pc;
    logic [31:0] sp;
    logic [2:0]  irq_mask;
    logic [1:0]  bank_sel;
    logic        pll_bypass_force;
    logic [2:0]  gear_sel;
    logic        boot_done;
    logic        core_run;

    always #2.5 clk = ~clk;

    rst_vector_seq i_rst_vector_seq (
        .clk              (clk),
        .rst              (rst),
        .ext_rst_n        (ext_rst_n),
        .rd_req           (rd_req),
        .rd_addr          (rd_addr),
        .rd_data          (rd_data),
        .rd_rdy           (rd_rdy),
        .pc               (pc),
        .sp               (sp),
        .irq_mask         (irq_mask),
        .bank_sel         (bank_sel),
        .pll_bypass_force (pll_bypass_force),
        .gear_sel         (gear_sel),
        .boot_done        (boot_done),
        .core_run         (core_run)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] vb [3];
    int wait_cyc = 0;
    int wc = 0;
    bit rdy_was = 1'b0;
    logic [23:0] addr_q [$];
    logic [23:0] pc_q [$];

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // memory model for the vector bytes
    always_comb begin
        if (rd_addr >= 24'hFFFF00 && rd_addr <= 24'hFFFF02) rd_data = vb[rd_addr - 24'hFFFF00];
        else rd_data = 8'hEE;
    end

    // responder: updates rd_rdy 1 ns after each rising edge
    always @(posedge clk) begin
        rdy_was = rd_rdy;
        #1;
        if (!rd_req) begin
            rd_rdy = 1'b0; wc = 0;
        end else if (rdy_was) begin
            rd_rdy = 1'b0; wc = 0;
        end else if (wc >= wait_cyc) begin
            rd_rdy = 1'b1;
        end else begin
            wc++;
        end
    end

    // monitor: pops expected items and compares mid-cycle
    bit prev_req = 1'b0, prev_xfer = 1'b0;
    logic [23:0] prev_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req && prev_req && !prev_xfer)
                chk(rd_addr == prev_addr, "R10 addr held during wait", rd_addr, prev_addr);
            if (rd_req && rd_rdy) begin
                if (addr_q.size() == 0) chk(1'b0, "R2 unexpected read", rd_addr, 0);
                else begin
                    logic [23:0] ea;
                    ea = addr_q.pop_front();
                    chk(rd_addr == ea, "R2 read address", rd_addr, ea);
                end
            end
            if (boot_done) begin
                if (pc_q.size() == 0) chk(1'b0, "R6 unexpected boot_done", pc, 0);
                else begin
                    logic [23:0] ep;
                    ep = pc_q.pop_front();
                    chk(pc == ep, "R3 pc at boot_done", pc, ep);
                end
                chk(!core_run, "R6 core_run low at boot_done", core_run, 0);
                chk(pll_bypass_force && gear_sel == 3'd4, "R5 clocks forced at boot_done",
                    {pll_bypass_force, gear_sel}, 4'hC);
            end
            prev_req  = rd_req;
            prev_xfer = rd_req && rd_rdy;
            prev_addr = rd_addr;
        end
    end

    task automatic pulse_low(int n);
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (n) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic expect_boot(logic [23:0] v);
        vb[0] = v[7:0]; vb[1] = v[15:8]; vb[2] = v[23:16];
        addr_q.push_back(24'hFFFF00);
        addr_q.push_back(24'hFFFF01);
        addr_q.push_back(24'hFFFF02);
        pc_q.push_back(v);
    endtask

    task automatic finish_boot(string tag);
        int guard = 0;
        while (!boot_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(boot_done, "R6 boot_done seen", boot_done, 1);
        @(negedge clk);
        chk(core_run && !boot_done, "R6 core_run after pulse", {core_run, boot_done}, 2'b10);
        chk(!pll_bypass_force && gear_sel == 3'd7, "R5 clocks released in run",
            {pll_bypass_force, gear_sel}, 4'h7);
        chk(addr_q.size() == 0 && pc_q.size() == 0, tag, addr_q.size(), 0);
    endtask

    task automatic boot(logic [23:0] v, int w, string tag);
        wait_cyc = w;
        expect_boot(v);
        pulse_low(20);
        @(negedge clk);
        chk(rd_req && rd_addr == 24'hFFFF00, "R2 first read after release", {rd_req, rd_addr}, {1'b1, 24'hFFFF00});
        finish_boot(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!rd_req && !boot_done && !core_run, "R9 held controls", {rd_req, boot_done, core_run}, 0);
        chk(pc == 24'h0, "R9 pc cleared", pc, 0);
        chk(sp == 32'h0 && irq_mask == 3'b111 && bank_sel == 2'b00, "R4 init values",
            {sp[3:0], irq_mask, bank_sel}, 9'h01C);
        chk(pll_bypass_force && gear_sel == 3'd4, "R5 forced clocks in rst", {pll_bypass_force, gear_sel}, 4'hC);
        rst = 1'b0;

        // R1 short pulse while held
        pulse_low(19);
        repeat (4) begin
            @(negedge clk);
            chk(!rd_req && !core_run, "R1 19-clock pulse ignored while held", {rd_req, core_run}, 0);
        end

        // R2 R3 R6 nominal boot, no waits
        boot(24'h123456, 0, "R2 all reads consumed");

        // R1 short pulse while running
        @(negedge clk);
        ext_rst_n = 1'b0;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            chk(core_run, "R1 core keeps running during short pulse", core_run, 1);
        end
        ext_rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(core_run && !rd_req, "R1 still running after short pulse", {core_run, rd_req}, 2'b10);
        end
        chk(pc == 24'h123456, "R1 pc kept after short pulse", pc, 24'h123456);

        // R10 boot with wait states
        boot(24'hA5C30F, 3, "R10 all reads consumed");

        // R8 R5 R4 pc cleared during long hold
        wait_cyc = 1;
        expect_boot(24'h00FF80);
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (23) @(negedge clk);
        chk(pc == 24'h0, "R8 pc zero while held", pc, 0);
        chk(!core_run && pll_bypass_force && gear_sel == 3'd4, "R5 clocks forced while held",
            {core_run, pll_bypass_force, gear_sel}, 5'h0C);
        chk(sp == 32'h0 && irq_mask == 3'b111 && bank_sel == 2'b00, "R4 init values on accept",
            {sp[3:0], irq_mask, bank_sel}, 9'h01C);
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
        finish_boot("R8 all reads consumed");

        // R7 abort during fetch
        wait_cyc = 10;
        pulse_low(20);
        @(negedge clk);
        @(negedge clk);
        chk(rd_req && !rd_rdy, "R7 read pending before abort", {rd_req, rd_rdy}, 2'b10);
        ext_rst_n = 1'b0;
        @(negedge clk);
        chk(!rd_req && !core_run, "R7 read dropped on abort", {rd_req, core_run}, 0);
        ext_rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!rd_req && !core_run, "R7 waits for new qualified reset", {rd_req, core_run}, 0);
        end
        boot(24'h7E0001, 1, "R7 reboot reads consumed");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule